// File: doc/BRIEF.md
# Cascadable Presettable Divide-by-N Counter

The block divides a clock by a programmable ratio N by counting down from a preset value. It is built as a chain of narrow down-counting digit stages that share one clock. Each stage raises a zero flag only when its own digit is zero and every more significant digit is also zero. The flag of the least significant stage marks the terminal count of the whole chain. That terminal flag acts as the preset enable for every stage, so the chain reloads by itself and no wide comparator is needed.

The design is fully synchronous. A clock-enable strobe `ce` marks the input events to be counted, and `inhibit` freezes the chain. On the enabled edge that leaves the all-zero state, the chain loads N and applies that edge's decrement in the same step, so it stores N-1. As a result, the zero flag is high for exactly one counted event in every N. A synchronous reset clears every digit, which puts the chain in the zero state, so the next enabled edge presets it.

Top module: `divn_counter`

## Requirements
- R1: While `rst` is high at a rising edge, every digit clears. In the cycle after that edge, `count_o` is 0 and `zero_o` and all bits of `stage_zero_o` are 1.
- R2: With `inhibit` high at an edge, `count_o` keeps its value. This includes the all-zero state, where the reload is also held off.
- R3: With `ce` low at an edge, `count_o` keeps its value, including in the all-zero state.
- R4: On an enabled edge (`ce` high, `inhibit` low) with a non-zero count, `count_o` falls by exactly one. `count_o` is read as one binary number, with stage 0 in bits [DIGIT_W-1:0].
- R5: On an enabled edge in the all-zero state with a non-zero `preset_i`, `count_o` becomes the value `preset_i` had at that edge, minus one.
- R6: With `preset_i` equal to zero, an enabled edge in the all-zero state leaves the count at zero, and `zero_o` stays high.
- R7: With a constant N of 1 or more and `ce` high every cycle, `zero_o` is high in exactly one cycle out of every N. For N = 1 it is high in every cycle.
- R8: `stage_zero_o[i]` is high exactly when digit i and every more significant digit are zero, and `zero_o` equals `stage_zero_o[0]`.
- R9: A digit moves from zero to all ones only when it borrows while some more significant digit is non-zero. A zero digit whose higher digits are all zero stays zero when no reload occurs.
- R10: After reset release, `zero_o` is low following the first enabled edge if N is 2 or more, and it stays high if N is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all digits so the next enabled edge presets the chain |
| ce | input | 1 | Count strobe; one counted event per cycle where it is high |
| inhibit | input | 1 | Holds the count and the reload while high |
| preset_i | input | STAGES*DIGIT_W | Division ratio N, stage 0 in the low bits |
| count_o | output | STAGES*DIGIT_W | Current count of the chain, stage 0 in the low bits |
| zero_o | output | 1 | Terminal zero of the chain: one pulse per N counted events |
| stage_zero_o | output | STAGES | Cascade zero flag of each stage |

## Verification
The assertions assume that `ce`, `inhibit` and `preset_i` are synchronous levels that are stable around each rising edge. They also assume that `rst` is held for at least one edge before any property is checked. The reload property compares against the preset value at the loading edge itself, so changing N during a count is legal and is exercised. The stimulus changes every input on the falling edge. It sweeps every N of a two-stage chain, applies a pseudo-random mix of strobe and inhibit, and changes N and applies reset in the middle of a count.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int unsigned DIVN_DIGIT_W_DEF = 4;
  localparam int unsigned DIVN_STAGES_DEF  = 3;
endpackage

// File: rtl/divn_stage.sv
module divn_stage
  import divn_pkg::*;
#(
  parameter int unsigned DIGIT_W = DIVN_DIGIT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               load,
  input  logic [DIGIT_W-1:0] preset_d,
  input  logic               dec_i,
  input  logic               cf_i,
  output logic [DIGIT_W-1:0] q_o,
  output logic               digit_zero_o,
  output logic               src_zero_o,
  output logic               zero_o
);
  logic [DIGIT_W-1:0] q_r;
  logic [DIGIT_W-1:0] src;
  logic [DIGIT_W-1:0] nxt;

  // Reload shares the decrementer: the digit source is either the preset or the held value
  always_comb begin
    src = load ? preset_d : q_r;
    nxt = dec_i ? (src - DIGIT_W'(1)) : src;
  end

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (en) q_r <= nxt;
  end

  assign q_o          = q_r;
  assign digit_zero_o = (q_r == '0);
  assign src_zero_o   = (src == '0);
  assign zero_o       = digit_zero_o & cf_i;

  // R9: a zero digit with all higher digits zero never wraps outside a reload
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q_r == '0 && cf_i) |=> (q_r == '0));
endmodule

// File: rtl/divn_chain.sv
module divn_chain
  import divn_pkg::*;
#(
  parameter int unsigned DIGIT_W = DIVN_DIGIT_W_DEF,
  parameter int unsigned STAGES  = DIVN_STAGES_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [STAGES*DIGIT_W-1:0]  preset_i,
  output logic [STAGES*DIGIT_W-1:0]  count_o,
  output logic [STAGES-1:0]          stage_zero_o,
  output logic                       term_o
);
  logic [STAGES-1:0] qz;
  logic [STAGES-1:0] cf;
  logic [STAGES-1:0] srcz;
  logic [STAGES-1:0] lowz;
  logic [STAGES-1:0] zq;
  logic [STAGES-1:0] dec;
  logic              term;
  logic              any_nz;

  assign term   = zq[0];
  assign any_nz = ~(&srcz);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    // Cascade feedback: every more significant digit is zero
    if (i == STAGES - 1) begin : g_top
      assign cf[i] = 1'b1;
    end else begin : g_mid
      assign cf[i] = &qz[STAGES-1:i+1];
    end

    // Borrow reaches digit i when every less significant source digit is zero
    if (i == 0) begin : g_lsd
      assign lowz[i] = 1'b1;
    end else begin : g_hsd
      assign lowz[i] = &srcz[i-1:0];
    end

    assign dec[i] = any_nz & lowz[i];

    divn_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk          (clk),
      .rst          (rst),
      .en           (en),
      .load         (term),
      .preset_d     (preset_i[i*DIGIT_W +: DIGIT_W]),
      .dec_i        (dec[i]),
      .cf_i         (cf[i]),
      .q_o          (count_o[i*DIGIT_W +: DIGIT_W]),
      .digit_zero_o (qz[i]),
      .src_zero_o   (srcz[i]),
      .zero_o       (zq[i])
    );

    if (i < STAGES - 1) begin : g_thermo
      // R8: a stage can only report zero if the next more significant stage does
      assert_zero_thermo_R8: assert property (@(posedge clk) disable iff (rst)
        zq[i] |-> zq[i+1]);
    end
  end

  assign stage_zero_o = zq;
  assign term_o       = term;
endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter int unsigned DIGIT_W = DIVN_DIGIT_W_DEF,
  parameter int unsigned STAGES  = DIVN_STAGES_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce,
  input  logic                      inhibit,
  input  logic [STAGES*DIGIT_W-1:0] preset_i,
  output logic [STAGES*DIGIT_W-1:0] count_o,
  output logic                      zero_o,
  output logic [STAGES-1:0]         stage_zero_o
);
  localparam int unsigned W = STAGES * DIGIT_W;

  logic en;
  assign en = ce & ~inhibit;

  divn_chain #(.DIGIT_W(DIGIT_W), .STAGES(STAGES)) u_chain (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .preset_i     (preset_i),
    .count_o      (count_o),
    .stage_zero_o (stage_zero_o),
    .term_o       (zero_o)
  );

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == '0 && zero_o && (&stage_zero_o)));

  assert_inhibit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> $stable(count_o));

  assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(count_o));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !zero_o) |=> (count_o == $past(count_o) - W'(1)));

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (en && zero_o && preset_i != '0) |=> (count_o == $past(preset_i) - W'(1)));

  assert_zero_ratio_R6: assert property (@(posedge clk) disable iff (rst)
    (en && zero_o && preset_i == '0) |=> (zero_o && count_o == '0));
endmodule

// File: tb/divn_counter_bench.sv
module divn_counter_bench;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned STAGES  = 2;
  localparam int unsigned W       = DIGIT_W * STAGES;

  logic                clk = 1'b0;
  logic                rst;
  logic                ce;
  logic                inhibit;
  logic [W-1:0]        preset;
  logic [W-1:0]        count_o;
  logic                zero_o;
  logic [STAGES-1:0]   stage_zero_o;

  int checks   = 0;
  int failures = 0;
  int zcount   = 0;
  bit done     = 1'b0;
  logic [W-1:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  divn_counter #(.DIGIT_W(DIGIT_W), .STAGES(STAGES)) u_divn_counter (
    .clk          (clk),
    .rst          (rst),
    .ce           (ce),
    .inhibit      (inhibit),
    .preset_i     (preset),
    .count_o      (count_o),
    .zero_o       (zero_o),
    .stage_zero_o (stage_zero_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One clock: update the arithmetic model at the edge, check at the falling edge
  task automatic cyc();
    logic [W-1:0] prev;
    string req;
    logic [STAGES-1:0] exp_sz;
    @(posedge clk);
    prev = exp_cnt;
    if (rst) begin
      exp_cnt = '0; req = "R1";
    end else if (inhibit) begin
      req = "R2";
    end else if (!ce) begin
      req = "R3";
    end else if (prev == '0) begin
      exp_cnt = (preset == '0) ? '0 : preset - W'(1);
      req = (preset == '0) ? "R6" : "R5";
    end else begin
      exp_cnt = prev - W'(1);
      req = (prev[DIGIT_W-1:0] == '0) ? "R9" : "R4";
    end
    @(negedge clk);
    for (int i = 0; i < STAGES; i++)
      exp_sz[i] = ((exp_cnt >> (i * DIGIT_W)) == '0);
    chk(count_o == exp_cnt, req, int'(count_o), int'(exp_cnt));
    chk(zero_o == (exp_cnt == '0), "R8", int'(zero_o), int'(exp_cnt == '0));
    chk(stage_zero_o == exp_sz, "R8", int'(stage_zero_o), int'(exp_sz));
    if (zero_o) zcount++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    chk(count_o == '0 && zero_o && (&stage_zero_o), "R1", int'(count_o), 0);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] lfsr;
    rst = 1'b1; ce = 1'b0; inhibit = 1'b0; preset = '0;
    cyc();
    cyc();
    rst = 1'b0;

    // Hold tests in the all-zero state: no reload may happen
    preset = W'(9);
    inhibit = 1'b1; ce = 1'b1;
    cyc(); cyc();
    inhibit = 1'b0; ce = 1'b0;
    cyc(); cyc();

    // Sweep every division ratio of the two-stage chain
    for (int n = 0; n < (1 << W); n++) begin
      int len;
      @(negedge clk);
      preset = W'(n);
      ce = 1'b0;
      do_reset();
      ce = 1'b1;
      zcount = 0;
      len = 2 * ((n == 0) ? 1 : n);
      cyc();
      chk(zero_o == (n < 2), "R10", int'(zero_o), int'(n < 2));
      for (int k = 1; k < len; k++) cyc();
      chk(zcount == 2, "R7", zcount, 2);
    end

    // Mixed strobe and inhibit pattern
    preset = W'(37);
    do_reset();
    lfsr = 8'hA5;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ce = lfsr[0] | lfsr[2];
      inhibit = lfsr[1] & lfsr[6];
      cyc();
    end

    // Ratio change during a count takes effect at the next reload
    ce = 1'b1; inhibit = 1'b0;
    preset = W'(200);
    do_reset();
    for (int k = 0; k < 10; k++) cyc();
    preset = W'(5);
    for (int k = 0; k < 210; k++) cyc();

    // Reset in the middle of a count
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    for (int k = 0; k < 12; k++) cyc();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule